// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block performs 32-bit signed and unsigned multiplication and division and commits each result pair to two architectural registers, HI and LO. An operation is offered on a valid/ready issue channel together with its two operands. Both results are written into HI/LO on the clock edge that accepts the operation. A busy counter is loaded on that edge with a modelled latency, and it counts down once per cycle. A request to read HI or LO while the counter is running raises a stall flag until the counter drains. For multiplies the modelled latency depends on how many significant bits the first operand has. Divides take a fixed time.

Division by zero and the one signed overflow case produce fixed, defined results rather than undefined ones. HI and LO can also be loaded directly. A direct load does not end the busy period. Issue-side back-pressure never occurs: `op_ready` is held high. A new operation is accepted in any cycle, including while an earlier one is still counting down, and it replaces the running count. On the read side the requester must hold `rd_req` and treat `rd_data` as valid only in a cycle where `rd_stall` is low.

Top module: `hilo_muldiv`

## Requirements
- R1: `op_ready` is always high, and every cycle with `op_valid` high issues one operation. `op_code` encodes 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide, 3 = unsigned divide.
- R2: A multiply writes the upper 32 bits of the 64-bit product into HI and the lower 32 bits into LO. Signed multiply treats both operands as two's complement; unsigned multiply treats them as unsigned.
- R3: A signed divide with a nonzero divisor truncates the quotient toward zero into LO. The remainder goes into HI and carries the sign of the dividend. An unsigned divide puts the quotient in LO and the remainder in HI.
- R4: A signed divide by zero writes the dividend into HI. LO receives 1 when the dividend is negative and 0xFFFFFFFF otherwise.
- R5: An unsigned divide by zero writes 0xFFFFFFFF into LO and the dividend into HI.
- R6: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R7: Either divide keeps the unit busy for 37 cycles after the accepting edge.
- R8: A multiply keeps the unit busy for 7 + 4*(2 - z/11) cycles, where z/11 is integer division and z is a leading-zero count. For unsigned multiply, z is taken from (A | 1). For signed multiply, z is taken from ((A xor (A arithmetically shifted right by 21)) | 1). Counts of 0 to 10 give 15 cycles, 11 to 21 give 11, and 22 to 31 give 7.
- R9: `rd_stall` is high when `rd_req` is high and the remaining busy count is nonzero and no larger than STALL_LIMIT. Otherwise `rd_stall` is low and `rd_data` shows LO (`rd_sel` = 0) or HI (`rd_sel` = 1). A read in the same cycle as an issue sees the values from before that issue.
- R10: Issuing a new operation while busy reloads the busy count with the new operation's latency.
- R11: `wr_hi_en` / `wr_lo_en` load `wr_data` into HI / LO on the next edge and take priority over a result from the same cycle. A direct load leaves the busy count running.
- R12: After reset HI and LO are zero and the unit is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation accepted (always high) |
| op_code | input | 2 | Operation select |
| op_a | input | 32 | First operand (dividend / multiplicand) |
| op_b | input | 32 | Second operand (divisor / multiplier) |
| rd_req | input | 1 | Request to read HI or LO |
| rd_sel | input | 1 | 0 selects LO, 1 selects HI |
| rd_stall | output | 1 | Read must wait |
| rd_data | output | 32 | Selected register value |
| wr_hi_en | input | 1 | Direct load of HI |
| wr_lo_en | input | 1 | Direct load of LO |
| wr_data | input | 32 | Data for direct loads |

## Verification
The bench builds two copies that share every input. One copy uses the default parameters, with STALL_LIMIT equal to the 37-cycle divide time, so every busy read stalls. The other copy sets STALL_LIMIT to 10. That second copy exposes the window in which a read with more cycles left than the limit goes through at once, and it shows the exact cycle where stalling begins. The default copy reaches all three multiply latencies, including the operand boundary between 11 and 7 cycles, and also the restart and direct-load cases.

// File: rtl/hilo_muldiv_pkg.sv
package hilo_muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } mdu_op_e;
endpackage

// File: rtl/hilo_muldiv_arith.sv
module hilo_muldiv_arith
  import hilo_muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  mdu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res_hi,
  output logic [W-1:0]   res_lo
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = W'(1);

  logic [2*W-1:0] ext_a, ext_b, prod;

  always_comb begin
    if (op == OP_MUL_S) begin
      ext_a = {{W{a[W-1]}}, a};
      ext_b = {{W{b[W-1]}}, b};
    end else begin
      ext_a = {{W{1'b0}}, a};
      ext_b = {{W{1'b0}}, b};
    end
    prod = ext_a * ext_b;
  end

  always_comb begin
    res_hi = '0;
    res_lo = '0;
    unique case (op)
      OP_MUL_S, OP_MUL_U: begin
        res_hi = prod[2*W-1:W];
        res_lo = prod[W-1:0];
      end
      OP_DIV_S: begin
        if (b == '0) begin
          res_hi = a;
          res_lo = a[W-1] ? ONE : ALL_ONES;
        end else if (a == MOST_NEG && b == ALL_ONES) begin
          res_hi = '0;
          res_lo = MOST_NEG;
        end else begin
          res_lo = $signed(a) / $signed(b);
          res_hi = $signed(a) % $signed(b);
        end
      end
      OP_DIV_U: begin
        if (b == '0) begin
          res_hi = a;
          res_lo = ALL_ONES;
        end else begin
          res_lo = a / b;
          res_hi = a % b;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hilo_muldiv_lat.sv
module hilo_muldiv_lat
  import hilo_muldiv_pkg::*;
#(
  parameter int W          = 32,
  parameter int CW         = 6,
  parameter int DIV_CYCLES = 37,
  parameter int MUL_BASE   = 7,
  parameter int MUL_STEP   = 4,
  parameter int MUL_GROUP  = 11,
  parameter int SIGN_SHIFT = 21
) (
  input  mdu_op_e       op,
  input  logic [W-1:0]  a,
  output logic [CW-1:0] lat
);
  localparam int MAX_GRP = (W - 1) / MUL_GROUP;

  logic signed [W-1:0] a_s, a_sh;
  logic [W-1:0]        probe;
  int                  lz;

  always_comb begin
    a_s  = a;
    a_sh = a_s >>> SIGN_SHIFT;
    if (op == OP_MUL_S) probe = a ^ a_sh;
    else                probe = a;
    probe = probe | W'(1);
    lz = W;
    for (int i = 0; i < W; i++) begin
      if (probe[i]) lz = W - 1 - i;
    end
    if (op == OP_DIV_S || op == OP_DIV_U)
      lat = CW'(DIV_CYCLES);
    else
      lat = CW'(MUL_BASE + (MAX_GRP - lz / MUL_GROUP) * MUL_STEP);
  end
endmodule

// File: rtl/hilo_muldiv_busy.sv
module hilo_muldiv_busy #(
  parameter int CW          = 6,
  parameter int STALL_LIMIT = 37
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          rd_req,
  output logic [CW-1:0] cnt,
  output logic          stall
);
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign stall = rd_req && (cnt != '0) && (int'(cnt) <= STALL_LIMIT);
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_muldiv_pkg::*;
#(
  parameter int W           = 32,
  parameter int DIV_CYCLES  = 37,
  parameter int MUL_BASE    = 7,
  parameter int MUL_STEP    = 4,
  parameter int MUL_GROUP   = 11,
  parameter int SIGN_SHIFT  = 21,
  parameter int STALL_LIMIT = 37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [1:0]   op_code,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic         rd_stall,
  output logic [W-1:0] rd_data,
  input  logic         wr_hi_en,
  input  logic         wr_lo_en,
  input  logic [W-1:0] wr_data
);
  localparam int MUL_MAX = MUL_BASE + ((W - 1) / MUL_GROUP) * MUL_STEP;
  localparam int MAX_LAT = (MUL_MAX > DIV_CYCLES) ? MUL_MAX : DIV_CYCLES;
  localparam int CW      = $clog2(MAX_LAT + 1);

  mdu_op_e       op_e;
  logic          op_fire;
  logic [W-1:0]  res_hi, res_lo;
  logic [W-1:0]  hi_q, lo_q;
  logic [CW-1:0] lat, busy_cnt;

  assign op_e     = mdu_op_e'(op_code);
  assign op_ready = 1'b1;
  assign op_fire  = op_valid && op_ready;

  hilo_muldiv_arith #(.W(W)) u_arith (
    .op     (op_e),
    .a      (op_a),
    .b      (op_b),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  hilo_muldiv_lat #(
    .W(W), .CW(CW), .DIV_CYCLES(DIV_CYCLES), .MUL_BASE(MUL_BASE),
    .MUL_STEP(MUL_STEP), .MUL_GROUP(MUL_GROUP), .SIGN_SHIFT(SIGN_SHIFT)
  ) u_lat (
    .op  (op_e),
    .a   (op_a),
    .lat (lat)
  );

  hilo_muldiv_busy #(.CW(CW), .STALL_LIMIT(STALL_LIMIT)) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (op_fire),
    .load_val (lat),
    .rd_req   (rd_req),
    .cnt      (busy_cnt),
    .stall    (rd_stall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi_en)     hi_q <= wr_data;
      else if (op_fire) hi_q <= res_hi;
      if (wr_lo_en)     lo_q <= wr_data;
      else if (op_fire) lo_q <= res_lo;
    end
  end

  assign rd_data = rd_sel ? hi_q : lo_q;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
  parameter int W          = 32,
  parameter int CW         = 6,
  parameter int DIV_CYCLES = 37,
  parameter int MUL_BASE   = 7,
  parameter int MUL_STEP   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_fire,
  input logic [1:0]    op_code,
  input logic [W-1:0]  op_b,
  input logic [CW-1:0] busy_cnt,
  input logic [W-1:0]  hi_q,
  input logic [W-1:0]  lo_q,
  input logic          wr_hi_en,
  input logic          wr_lo_en,
  input logic [W-1:0]  wr_data,
  input logic          rd_req,
  input logic          rd_stall
);
  p_div_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire && op_code[1] |=> busy_cnt == CW'(DIV_CYCLES));

  // R8: three magnitude groups at the default width
  p_mul_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire && !op_code[1] |=> (busy_cnt == CW'(MUL_BASE)) ||
                               (busy_cnt == CW'(MUL_BASE + MUL_STEP)) ||
                               (busy_cnt == CW'(MUL_BASE + 2 * MUL_STEP)));

  p_countdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_fire && busy_cnt != '0 |=> busy_cnt == CW'($past(busy_cnt) - 1'b1));

  p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> rd_req && busy_cnt != '0);

  p_wr_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_en |=> hi_q == $past(wr_data));

  p_hold_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_fire && !wr_hi_en |=> $stable(hi_q));

  p_divu_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire && op_code == 2'b11 && op_b == '0 && !wr_lo_en |=> lo_q == '1);
endmodule

bind hilo_muldiv hilo_muldiv_chk #(
  .W(W), .CW(CW), .DIV_CYCLES(DIV_CYCLES), .MUL_BASE(MUL_BASE), .MUL_STEP(MUL_STEP)
) i_chk (
  .clk(clk), .rst_n(rst_n), .op_fire(op_fire), .op_code(op_code), .op_b(op_b),
  .busy_cnt(busy_cnt), .hi_q(hi_q), .lo_q(lo_q), .wr_hi_en(wr_hi_en),
  .wr_lo_en(wr_lo_en), .wr_data(wr_data), .rd_req(rd_req), .rd_stall(rd_stall)
);

// File: tb/test_hilo_muldiv.sv
module test_hilo_muldiv;
  localparam logic [1:0] MUL_S = 2'd0, MUL_U = 2'd1, DIV_S = 2'd2, DIV_U = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready, op_ready_l;
  logic [1:0]  op_code = 2'd0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        rd_req = 1'b0, rd_sel = 1'b0;
  logic        rd_stall, rd_stall_l;
  logic [31:0] rd_data, rd_data_l;
  logic        wr_hi_en = 1'b0, wr_lo_en = 1'b0;
  logic [31:0] wr_data = '0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  hilo_muldiv i_hilo_muldiv (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_stall(rd_stall), .rd_data(rd_data), .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en),
    .wr_data(wr_data)
  );

  hilo_muldiv #(.STALL_LIMIT(10)) i_hilo_muldiv_lim (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready_l),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_stall(rd_stall_l), .rd_data(rd_data_l), .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en),
    .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_stall(output int n);
    n = 0;
    while (rd_stall && n < 200) begin
      @(negedge clk); #1; n++;
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] exp_hi,
                        input logic [31:0] exp_lo, input int exp_lat);
    int n;
    issue(op, a, b);
    rd_req = 1'b1; rd_sel = 1'b0; #1;
    wait_stall(n);
    check({req, " latency"}, 32'(n), 32'(exp_lat));
    check({req, " LO"}, rd_data, exp_lo);
    rd_sel = 1'b1; #1;
    check({req, " HI"}, rd_data, exp_hi);
    rd_req = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rd_req = 1'b1; rd_sel = 1'b0; #1;
    check("R12 stall", {31'd0, rd_stall}, 32'd0);
    check("R12 LO", rd_data, 32'd0);
    rd_sel = 1'b1; #1;
    check("R12 HI", rd_data, 32'd0);
    check("R1 ready", {31'd0, op_ready}, 32'd1);
    rd_req = 1'b0;
  endtask

  task automatic t_multiply();
    run_op("R2 R8 smul small", MUL_S, 32'hFFFF_FFFD, 32'd7, 32'hFFFF_FFFF, 32'hFFFF_FFEB, 7);
    run_op("R2 R8 umul top bit", MUL_U, 32'h8000_0000, 32'd4, 32'd2, 32'd0, 15);
    run_op("R2 R8 umul lz11", MUL_U, 32'h0010_0000, 32'h10, 32'd0, 32'h0100_0000, 11);
    run_op("R2 R8 umul lz21", MUL_U, 32'h0000_0400, 32'd3, 32'd0, 32'h0000_0C00, 11);
    run_op("R2 R8 umul lz22", MUL_U, 32'h0000_0200, 32'd3, 32'd0, 32'h0000_0600, 7);
    run_op("R2 R8 smul big", MUL_S, 32'h4000_0000, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h8000_0000, 15);
  endtask

  task automatic t_divide();
    run_op("R3 R7 sdiv -7/2", DIV_S, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 37);
    run_op("R3 R7 sdiv 7/-2", DIV_S, 32'd7, 32'hFFFF_FFFE, 32'd1, 32'hFFFF_FFFD, 37);
    run_op("R3 R7 udiv 100/7", DIV_U, 32'd100, 32'd7, 32'd2, 32'd14, 37);
  endtask

  task automatic t_div_zero();
    run_op("R4 sdiv neg by 0", DIV_S, 32'hFFFF_FFFB, 32'd0, 32'hFFFF_FFFB, 32'd1, 37);
    run_op("R4 sdiv pos by 0", DIV_S, 32'd9, 32'd0, 32'd9, 32'hFFFF_FFFF, 37);
    run_op("R4 sdiv zero by 0", DIV_S, 32'd0, 32'd0, 32'd0, 32'hFFFF_FFFF, 37);
    run_op("R5 udiv by 0", DIV_U, 32'h8000_0001, 32'd0, 32'h8000_0001, 32'hFFFF_FFFF, 37);
  endtask

  task automatic t_overflow();
    run_op("R6 overflow", DIV_S, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 32'h8000_0000, 37);
  endtask

  task automatic t_restart();
    issue(DIV_S, 32'd1, 32'd1);
    repeat (5) @(negedge clk);
    run_op("R10 restart", MUL_U, 32'd1, 32'd5, 32'd0, 32'd5, 7);
  endtask

  task automatic t_same_cycle_read();
    int n;
    @(negedge clk);
    op_valid = 1'b1; op_code = DIV_U; op_a = 32'd9; op_b = 32'd3;
    rd_req = 1'b1; rd_sel = 1'b0; #1;
    check("R9 same-cycle stall", {31'd0, rd_stall}, 32'd0);
    check("R9 same-cycle old LO", rd_data, 32'd5);
    @(negedge clk);
    op_valid = 1'b0; #1;
    wait_stall(n);
    check("R9 new LO", rd_data, 32'd3);
    rd_req = 1'b0;
  endtask

  task automatic t_limit();
    issue(DIV_U, 32'd50, 32'd5);
    rd_req = 1'b1; rd_sel = 1'b0; #1;
    check("R9 limit no stall", {31'd0, rd_stall_l}, 32'd0);
    check("R9 limit data", rd_data_l, 32'd10);
    check("R9 default stalls", {31'd0, rd_stall}, 32'd1);
    repeat (26) @(negedge clk);
    #1;
    check("R9 limit 11 left", {31'd0, rd_stall_l}, 32'd0);
    @(negedge clk); #1;
    check("R9 limit 10 left", {31'd0, rd_stall_l}, 32'd1);
    while (rd_stall) begin @(negedge clk); #1; end
    rd_req = 1'b0;
  endtask

  task automatic t_direct_write();
    int n;
    issue(DIV_U, 32'd20, 32'd3);
    wr_hi_en = 1'b1; wr_data = 32'h0000_ABCD;
    @(negedge clk);
    wr_hi_en = 1'b0;
    rd_req = 1'b1; rd_sel = 1'b1; #1;
    check("R11 busy kept", {31'd0, rd_stall}, 32'd1);
    wait_stall(n);
    check("R11 remaining", 32'(n), 32'd36);
    check("R11 HI loaded", rd_data, 32'h0000_ABCD);
    rd_sel = 1'b0; #1;
    check("R11 LO result", rd_data, 32'd6);
    rd_req = 1'b0;
    @(negedge clk);
    op_valid = 1'b1; op_code = MUL_U; op_a = 32'h8000_0000; op_b = 32'd4;
    wr_lo_en = 1'b1; wr_data = 32'h55;
    @(negedge clk);
    op_valid = 1'b0; wr_lo_en = 1'b0;
    rd_req = 1'b1; rd_sel = 1'b0; #1;
    wait_stall(n);
    check("R11 priority LO", rd_data, 32'h55);
    rd_sel = 1'b1; #1;
    check("R11 HI from op", rd_data, 32'd2);
    rd_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_multiply();
    t_divide();
    t_div_zero();
    t_overflow();
    t_restart();
    t_same_cycle_read();
    t_limit();
    t_direct_write();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule